// File: doc/BRIEF.md
# Vector Byte Permutation Engine

This block rearranges the bytes of 128-bit vectors in a single registered stage. An operation code selects one of twelve permutations: a byte-window extract across a pair of vectors, element reversal inside 16-, 32- or 64-bit containers, a one-register table lookup in two flavours (zero fill or keep the old destination byte for an out-of-range index), and the primary and secondary forms of transpose, interleave and de-interleave. An element-size code sets the lane granularity for the reversal, transpose, interleave and de-interleave operations.

A request is presented with `valid_in` high for one clock, together with every operand it needs. The permuted vector appears on `result` after the next rising edge with `valid_out` high for that cycle. Requests may be issued on every clock. A two-state output controller tracks whether a fresh result is present. ST_IDLE means no new result is on the output. ST_EMIT means the result register was loaded on the last edge. The transition ST_IDLE to ST_EMIT and the transition ST_EMIT to ST_EMIT both occur on an edge where `valid_in` is high. The transition ST_EMIT to ST_IDLE and the transition ST_IDLE to ST_IDLE both occur on an edge where `valid_in` is low. Reset forces ST_IDLE.

Top module: `vperm_unit`

## Requirements
- R1: While `rst_n` is low and after it is released with no request yet made, `valid_out` is 0 and `result` is all zero.
- R2: A request accepted at a rising edge gives `valid_out` = 1 and the new `result` after that edge, for exactly one cycle unless another request follows. Cycles with `valid_in` = 0 leave `result` unchanged, whatever the other inputs do.
- R3: Opcode 0 (extract) forms a 32-byte value with `src_a` as the upper 16 bytes and `src_b` as the lower 16. Result byte i is byte i+`imm` of that value. Therefore `imm` = 0 returns `src_b`.
- R4: Opcodes 1, 2 and 3 reverse the order of elements inside containers of 2, 4 and 8 bytes of `src_a`. The element width is 1, 2, 4 or 8 bytes for `esize` 0, 1, 2 or 3. An element as wide as its container, or wider, leaves `src_a` unchanged.
- R5: Opcode 4 (lookup) sets result byte i to byte k of `table_v`, where k is byte i of `index_v`, if k < 16. If k is 16 or more (including 255), result byte i is 0.
- R6: Opcode 5 (lookup-keep) behaves like opcode 4, except that an out-of-range index gives byte i of `dest_prev`.
- R7: Opcode 6 (transpose primary) sets result element 2p to element 2p of `src_a` and result element 2p+1 to element 2p of `src_b`. Opcode 7 (transpose secondary) does the same with the odd elements 2p+1 of each source.
- R8: Opcode 8 (interleave low) sets result elements 2k and 2k+1 to element k of `src_a` and element k of `src_b`, for the lower half of the element indices. Opcode 9 (interleave high) does the same using the upper-half elements of each source.
- R9: Opcode 10 (de-interleave even) fills the lower half of the result with the even elements of `src_a` and the upper half with the even elements of `src_b`. Opcode 11 (de-interleave odd) does the same with the odd elements.
- R10: Opcodes 12 to 15 produce an all-zero result, which is still flagged by `valid_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe; operands are sampled on this edge |
| op | input | 4 | Permutation code (0 to 11 defined) |
| esize | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| imm | input | 4 | Byte offset for extract |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| table_v | input | 128 | 16-byte lookup table |
| index_v | input | 128 | Sixteen byte indices for lookup |
| dest_prev | input | 128 | Prior destination contents for lookup-keep |
| valid_out | output | 1 | Result strobe, one cycle per request |
| result | output | 128 | Registered permuted vector |

## Verification
The assertions rely on operands being held steady around the sampling edge and on `valid_in` being a known level whenever reset is released. The index and destination properties look only at byte 0. They therefore assume that the lookup datapath is the same for every lane. The stimulus changes inputs only on falling edges. Every request supplies all operands together, with index bytes drawn both inside and outside the table range. During idle gaps the stimulus deliberately scrambles the data inputs, so that any leakage into a held result would show up.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    typedef logic [3:0] perm_op_t;

    localparam perm_op_t OPC_EXT     = 4'd0;
    localparam perm_op_t OPC_REV16   = 4'd1;
    localparam perm_op_t OPC_REV32   = 4'd2;
    localparam perm_op_t OPC_REV64   = 4'd3;
    localparam perm_op_t OPC_LOOKUP  = 4'd4;
    localparam perm_op_t OPC_LOOKUPK = 4'd5;
    localparam perm_op_t OPC_TRN_EV  = 4'd6;
    localparam perm_op_t OPC_TRN_OD  = 4'd7;
    localparam perm_op_t OPC_ZIP_LO  = 4'd8;
    localparam perm_op_t OPC_ZIP_HI  = 4'd9;
    localparam perm_op_t OPC_UZP_EV  = 4'd10;
    localparam perm_op_t OPC_UZP_OD  = 4'd11;

    // interleave family selector
    typedef enum logic [1:0] {
        MIX_TRN = 2'd0,
        MIX_ZIP = 2'd1,
        MIX_UZP = 2'd2
    } mix_kind_e;

    // output controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

endpackage

// File: rtl/vperm_shift_rev.sv
module vperm_shift_rev #(
    parameter int LANES = 16,
    parameter int BW    = 8
) (
    input  logic [LANES*BW-1:0]       vec_hi,
    input  logic [LANES*BW-1:0]       vec_lo,
    input  logic [$clog2(LANES)-1:0]  offset,
    input  logic [1:0]                elem_log,
    input  logic [1:0]                cont_log,
    output logic [LANES*BW-1:0]       window_out,
    output logic [LANES*BW-1:0]       flip_out
);
    localparam int VEC_W = LANES * BW;
    localparam int IDX_W = $clog2(LANES);

    logic [2*VEC_W-1:0] pair;
    logic [IDX_W-1:0]   cont_mask;
    logic [IDX_W-1:0]   elem_mask;
    logic [IDX_W-1:0]   flip_mask;

    assign pair      = {vec_hi, vec_lo};
    assign cont_mask = IDX_W'((1 << cont_log) - 1);
    assign elem_mask = IDX_W'((1 << elem_log) - 1);
    assign flip_mask = cont_mask & ~elem_mask;

    // sliding byte window over the concatenated pair
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [IDX_W:0] pos;
            pos = (IDX_W+1)'(i) + (IDX_W+1)'(offset);
            window_out[i*BW +: BW] = pair[pos*BW +: BW];
        end
    end

    // element reversal inside containers: flip the address bits between
    // the element size and the container size
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [IDX_W-1:0] src;
            src = IDX_W'(i) ^ flip_mask;
            flip_out[i*BW +: BW] = vec_hi[src*BW +: BW];
        end
    end

endmodule

// File: rtl/vperm_lookup.sv
module vperm_lookup #(
    parameter int LANES = 16,
    parameter int BW    = 8
) (
    input  logic [LANES*BW-1:0] table_v,
    input  logic [LANES*BW-1:0] index_v,
    input  logic [LANES*BW-1:0] dest_prev,
    input  logic                keep_oob,
    output logic [LANES*BW-1:0] lookup_out
);
    localparam int IDX_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BW-1:0]    key;
        logic [IDX_W-1:0] sel;
        logic             in_range;

        assign key      = index_v[g*BW +: BW];
        assign sel      = key[IDX_W-1:0];
        assign in_range = (int'(key) < LANES);

        always_comb begin
            if (in_range)
                lookup_out[g*BW +: BW] = table_v[sel*BW +: BW];
            else if (keep_oob)
                lookup_out[g*BW +: BW] = dest_prev[g*BW +: BW];
            else
                lookup_out[g*BW +: BW] = '0;
        end
    end

endmodule

// File: rtl/vperm_interleave.sv
module vperm_interleave
    import vperm_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BW    = 8
) (
    input  logic [LANES*BW-1:0] vec_a,
    input  logic [LANES*BW-1:0] vec_b,
    input  logic [1:0]          elem_log,
    input  mix_kind_e           kind,
    input  logic                odd_sel,
    output logic [LANES*BW-1:0] mix_out
);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            int  ebytes;
            int  nelem;
            int  j;
            int  off;
            int  k;
            int  p;
            int  sb;
            logic from_b;

            ebytes = 1 << elem_log;
            nelem  = LANES >> elem_log;
            j      = i >> elem_log;
            off    = i & (ebytes - 1);
            from_b = 1'b0;
            k      = 0;
            p      = 0;
            unique case (kind)
                MIX_TRN: begin
                    from_b = j[0];
                    k      = (j & ~1) | int'(odd_sel);
                end
                MIX_ZIP: begin
                    from_b = j[0];
                    k      = (j >> 1) + (odd_sel ? (nelem >> 1) : 0);
                end
                MIX_UZP: begin
                    p      = 2 * j + int'(odd_sel);
                    from_b = (p >= nelem);
                    k      = from_b ? (p - nelem) : p;
                end
                default: begin
                    from_b = 1'b0;
                    k      = j;
                end
            endcase
            sb = k * ebytes + off;
            mix_out[i*BW +: BW] = from_b ? vec_b[sb*BW +: BW] : vec_a[sb*BW +: BW];
        end
    end

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
#(
    parameter int LANES = 16,
    parameter int BW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_in,
    input  logic [3:0]                op,
    input  logic [1:0]                esize,
    input  logic [$clog2(LANES)-1:0]  imm,
    input  logic [LANES*BW-1:0]       src_a,
    input  logic [LANES*BW-1:0]       src_b,
    input  logic [LANES*BW-1:0]       table_v,
    input  logic [LANES*BW-1:0]       index_v,
    input  logic [LANES*BW-1:0]       dest_prev,
    output logic                      valid_out,
    output logic [LANES*BW-1:0]       result
);
    localparam int VEC_W = LANES * BW;

    out_state_e          state_q;
    out_state_e          state_d;
    logic [VEC_W-1:0]    window_v;
    logic [VEC_W-1:0]    flip_v;
    logic [VEC_W-1:0]    lookup_v;
    logic [VEC_W-1:0]    mix_v;
    logic [VEC_W-1:0]    perm_d;
    logic [VEC_W-1:0]    result_q;
    logic [1:0]          cont_log;
    mix_kind_e           mix_kind;
    logic                keep_oob;

    // datapath control decode
    always_comb begin
        cont_log = 2'd1;
        if (op == OPC_REV32) cont_log = 2'd2;
        if (op == OPC_REV64) cont_log = 2'd3;
        keep_oob = (op == OPC_LOOKUPK);
        unique case (op)
            OPC_ZIP_LO, OPC_ZIP_HI: mix_kind = MIX_ZIP;
            OPC_UZP_EV, OPC_UZP_OD: mix_kind = MIX_UZP;
            default:                mix_kind = MIX_TRN;
        endcase
    end

    vperm_shift_rev #(.LANES(LANES), .BW(BW)) u_shift_rev (
        .vec_hi     (src_a),
        .vec_lo     (src_b),
        .offset     (imm),
        .elem_log   (esize),
        .cont_log   (cont_log),
        .window_out (window_v),
        .flip_out   (flip_v)
    );

    vperm_lookup #(.LANES(LANES), .BW(BW)) u_lookup (
        .table_v    (table_v),
        .index_v    (index_v),
        .dest_prev  (dest_prev),
        .keep_oob   (keep_oob),
        .lookup_out (lookup_v)
    );

    vperm_interleave #(.LANES(LANES), .BW(BW)) u_interleave (
        .vec_a    (src_a),
        .vec_b    (src_b),
        .elem_log (esize),
        .kind     (mix_kind),
        .odd_sel  (op[0]),
        .mix_out  (mix_v)
    );

    // result select
    always_comb begin
        unique case (op)
            OPC_EXT:                           perm_d = window_v;
            OPC_REV16, OPC_REV32, OPC_REV64:   perm_d = flip_v;
            OPC_LOOKUP, OPC_LOOKUPK:           perm_d = lookup_v;
            OPC_TRN_EV, OPC_TRN_OD,
            OPC_ZIP_LO, OPC_ZIP_HI,
            OPC_UZP_EV, OPC_UZP_OD:            perm_d = mix_v;
            default:                           perm_d = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_in ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = valid_in ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (valid_in) result_q <= perm_d;
    end

    assign valid_out = (state_q == ST_EMIT);
    assign result    = result_q;

    // R2: a request yields a strobe on the following cycle
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    // R2: no request, no strobe and a held result
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!valid_out && $stable(result)));
    // R3: zero offset passes the low source through
    a_r3_ext_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == OPC_EXT && imm == '0) |=> (result == $past(src_b)));
    // R5: out-of-range index in lane 0 gives zero
    a_r5_lookup_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == OPC_LOOKUP && int'(index_v[BW-1:0]) >= LANES)
        |=> (result[BW-1:0] == '0));
    // R6: out-of-range index in lane 0 keeps the old destination byte
    a_r6_lookupk_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == OPC_LOOKUPK && int'(index_v[BW-1:0]) >= LANES)
        |=> (result[BW-1:0] == $past(dest_prev[BW-1:0])));
    // R7: byte-wide transpose primary, first pair
    a_r7_trn_first_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op == OPC_TRN_EV && esize == 2'd0)
        |=> (result[2*BW-1:0] == {$past(src_b[BW-1:0]), $past(src_a[BW-1:0])}));
    // R10: undefined codes give zero
    a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op > OPC_UZP_OD) |=> (result == '0));

endmodule

// File: tb/vperm_unit_bench.sv
module vperm_unit_bench;

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [3:0]   op = '0;
    logic [1:0]   esize = '0;
    logic [3:0]   imm = '0;
    logic [127:0] src_a = '0, src_b = '0, table_v = '0, index_v = '0, dest_prev = '0;
    logic         valid_out;
    logic [127:0] result;

    int checks = 0;
    int bad = 0;
    int cycles = 0;
    item_t sb_q[$];
    logic [127:0] last_exp = '0;
    bit have_last = 0;

    always #10 clk = ~clk;

    vperm_unit u_vperm_unit (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .esize(esize),
        .imm(imm), .src_a(src_a), .src_b(src_b), .table_v(table_v),
        .index_v(index_v), .dest_prev(dest_prev), .valid_out(valid_out),
        .result(result)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R3";
            4'd1, 4'd2, 4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6, 4'd7: return "R7";
            4'd8, 4'd9: return "R8";
            4'd10, 4'd11: return "R9";
            default: return "R10";
        endcase
    endfunction

    // element-level reference model
    function automatic logic [127:0] model(input logic [3:0] o, input logic [1:0] es,
            input logic [3:0] im, input logic [127:0] a, input logic [127:0] b,
            input logic [127:0] t, input logic [127:0] x, input logic [127:0] d);
        logic [7:0] A[16], B[16], T[16], X[16], D[16], R[16];
        logic [127:0] packed_r;
        int E, N, C, s;
        for (int i = 0; i < 16; i++) begin
            A[i] = a[i*8 +: 8]; B[i] = b[i*8 +: 8]; T[i] = t[i*8 +: 8];
            X[i] = x[i*8 +: 8]; D[i] = d[i*8 +: 8]; R[i] = 8'h00;
        end
        E = 1 << es;
        N = 16 / E;
        case (o)
            4'd0: for (int i = 0; i < 16; i++)
                      R[i] = (i + int'(im) < 16) ? B[i + int'(im)] : A[i + int'(im) - 16];
            4'd1, 4'd2, 4'd3: begin
                C = 2 << (int'(o) - 1);
                if (E >= C) begin
                    for (int i = 0; i < 16; i++) R[i] = A[i];
                end else begin
                    for (int base = 0; base < 16; base += C)
                        for (int k = 0; k < C / E; k++)
                            for (int q = 0; q < E; q++)
                                R[base + k*E + q] = A[base + (C/E - 1 - k)*E + q];
                end
            end
            4'd4, 4'd5: for (int i = 0; i < 16; i++)
                      R[i] = (X[i] < 16) ? T[X[i][3:0]] : ((o == 4'd5) ? D[i] : 8'h00);
            4'd6, 4'd7: begin
                s = int'(o) - 6;
                for (int p = 0; p < N/2; p++)
                    for (int q = 0; q < E; q++) begin
                        R[(2*p)*E + q]   = A[(2*p + s)*E + q];
                        R[(2*p+1)*E + q] = B[(2*p + s)*E + q];
                    end
            end
            4'd8, 4'd9: begin
                s = (int'(o) - 8) * (N/2);
                for (int k = 0; k < N/2; k++)
                    for (int q = 0; q < E; q++) begin
                        R[(2*k)*E + q]   = A[(s + k)*E + q];
                        R[(2*k+1)*E + q] = B[(s + k)*E + q];
                    end
            end
            4'd10, 4'd11: begin
                s = int'(o) - 10;
                for (int k = 0; k < N/2; k++)
                    for (int q = 0; q < E; q++) begin
                        R[k*E + q]         = A[(2*k + s)*E + q];
                        R[(N/2 + k)*E + q] = B[(2*k + s)*E + q];
                    end
            end
            default: ;
        endcase
        for (int i = 0; i < 16; i++) packed_r[i*8 +: 8] = R[i];
        return packed_r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic send(input logic [3:0] o, input logic [1:0] es, input logic [3:0] im,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] t,
            input logic [127:0] x, input logic [127:0] d);
        item_t it;
        @(negedge clk);
        valid_in = 1'b1; op = o; esize = es; imm = im;
        src_a = a; src_b = b; table_v = t; index_v = x; dest_prev = d;
        it.exp = model(o, es, im, a, b, t, x, d);
        it.tag = tag_of(o);
        sb_q.push_back(it);
    endtask

    // idle cycles with scrambled operands: they must not reach the result (R2)
    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            valid_in = 1'b0; op = 4'($urandom); esize = 2'($urandom);
            imm = 4'($urandom);
            src_a = rnd128(); src_b = rnd128(); table_v = rnd128();
            index_v = rnd128(); dest_prev = rnd128();
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_out) begin
                checks++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL R2 strobe with no request: actual valid_out=1 expected 0");
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    if (result !== it.exp) begin
                        bad++;
                        $display("FAIL %s result actual=%h expected=%h", it.tag, result, it.exp);
                    end
                    last_exp = it.exp;
                    have_last = 1;
                end
            end else if (have_last) begin
                checks++;
                if (result !== last_exp) begin
                    bad++;
                    $display("FAIL R2 held result actual=%h expected=%h", result, last_exp);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL R2 watchdog expired: actual cycles=%0d expected below 20000", cycles);
            summary();
            $finish;
        end
    end

    localparam logic [127:0] SEQ_A = 128'h0f0e0d0c0b0a09080706050403020100;
    localparam logic [127:0] SEQ_B = 128'h1f1e1d1c1b1a19181716151413121110;

    initial begin
        logic [127:0] idx;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        checks++;
        if (valid_out !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R1 in reset actual=%b/%h expected=0/0", valid_out, result);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (valid_out !== 1'b0 || result !== '0) begin
            bad++;
            $display("FAIL R1 after release actual=%b/%h expected=0/0", valid_out, result);
        end

        // R3: extract corners
        send(4'd0, 2'd0, 4'd0,  SEQ_A, SEQ_B, '0, '0, '0);
        send(4'd0, 2'd0, 4'd15, SEQ_A, SEQ_B, '0, '0, '0);
        send(4'd0, 2'd0, 4'd3,  SEQ_A, SEQ_B, '0, '0, '0);
        idle(2);
        // R4: every container / element combination, including pass-through
        for (int o = 1; o <= 3; o++)
            for (int e = 0; e < 4; e++)
                send(4'(o), 2'(e), 4'd0, SEQ_A, SEQ_B, '0, '0, '0);
        // R5 / R6: index bytes at 0, 15, 16, 255 and mixed
        idx = 128'hff_10_0f_00_ff_20_01_0e_7f_11_05_0a_80_10_0f_00;
        send(4'd4, 2'd0, 4'd0, SEQ_A, SEQ_B, SEQ_B, idx, rnd128());
        send(4'd5, 2'd0, 4'd0, SEQ_A, SEQ_B, SEQ_B, idx, rnd128());
        send(4'd5, 2'd0, 4'd0, SEQ_A, SEQ_B, SEQ_B, {16{8'hff}}, SEQ_A);
        idle(1);
        // R7 / R8 / R9: each form at each element width
        for (int o = 6; o <= 11; o++)
            for (int e = 0; e < 4; e++)
                send(4'(o), 2'(e), 4'd0, SEQ_A, SEQ_B, '0, '0, '0);
        // R10: undefined codes
        for (int o = 12; o <= 15; o++)
            send(4'(o), 2'(o), 4'd5, SEQ_A, SEQ_B, SEQ_A, '0, SEQ_B);
        idle(3);
        // random traffic with gaps
        for (int n = 0; n < 300; n++) begin
            send(4'($urandom), 2'($urandom), 4'($urandom), rnd128(), rnd128(),
                 rnd128(), rnd128() & {16{8'h1f}}, rnd128());
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 2)));
        end
        idle(4);
        checks++;
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL R2 missing results actual=%0d pending expected=0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule